// File: doc/BRIEF.md
# Compressed stack push/pop micro-op sequencer

This block sits between the fetch side and the execute stage of a simple in-order RV32 core. It takes 16-bit compressed words. When a word is one of the compressed stack instructions (register-list push, pop, pop-and-return, pop-and-return-with-zero) or one of the two paired register moves, the block turns it into a stream of ordinary 32-bit instructions. The stream is handed to the execute stage one word at a time under a valid/ready handshake. Any other compressed word passes by without effect; decoding those words belongs to another unit.

While a stream is running, the block gives the execute stage what it needs to treat the stream as one architectural instruction. It holds the address of the originating instruction and the sequential address that follows it. It raises a start flag until the first micro-op has been taken. It emits one retire pulse per stream. It also raises a flag over the tail of a return stream, so that the trap logic can hold off interrupts and exceptions until the tail has issued.

Top module: `zcmp_seq`

## Requirements
- R1: A word with bits [1:0]=10 and bits [15:13]=101 is a stack instruction selected by bits [12:8]: 11000 push, 11010 pop, 11110 pop-and-return, 11100 pop-and-return-with-zero. The register list is in bits [7:4], and the extra stack amount spimm is in bits [3:2].
- R2: In the same group, bits [12:10]=011 with bits [6:5]=01 moves a0 into sreg(bits[9:7]) and then a1 into sreg(bits[4:2]). With bits [6:5]=11, the moves go the other way, a0 from the first register and then a1 from the second. Each move is emitted as `addi rd, rs, 0`. The mapping sreg(i) gives x8+i for i<2 and x16+i otherwise.
- R3: The `illegal` output is high combinationally while `cvalid` is high, `in_seq` is low and the word is in the group but not legal. This covers any other bits [12:8] value, a double move with bits [6:5] of 00 or 10, and a stack instruction with a register list below 4. No stream starts for such a word.
- R4: Register list value r saves n registers, where n = r-3 for r from 4 to 14 and n = 13 for r = 15. Register k of the list is x1 for k=0, x8 for k=1, x9 for k=2 and x(15+k) otherwise. The adjustment is adj = roundup16(4n) + 16*spimm. A push emits `sw reg_k, -4(k+1)(x2)` for k = 0..n-1, then `addi x2, x2, -adj`.
- R5: A pop emits `lw reg_k, adj-4(k+1)(x2)` for k = 0..n-1, then `addi x2, x2, adj`. A pop-and-return-with-zero then adds `addi x10, x0, 0`. Both return forms end with `jalr x0, 0(x1)`.
- R6: `held_pc` takes `pc_in` when a word is accepted and keeps that value for the whole stream. `seq_next_pc` equals `held_pc + 2`.
- R7: A micro-op with `uop_valid` high stays unchanged until `ex_ready` is high. The next micro-op follows on the cycle after the handshake.
- R8: `seq_start` is high from the cycle after acceptance until the first micro-op has been taken. `retire` pulses exactly once per stream, on the handshake of its first micro-op.
- R9: `atomic_tail` is high exactly while the last micro-op of a pop-and-return is offered, or the last two of a pop-and-return-with-zero. It is never high for any other stream.
- R10: Words presented while `in_seq` is high are ignored. Words outside the group start nothing and raise no `illegal`.
- R11: After reset, `in_seq`, `uop_valid`, `seq_start`, `atomic_tail` and `retire` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cinstr | input | 16 | Compressed instruction word |
| cvalid | input | 1 | cinstr is valid |
| pc_in | input | PC_W | Address of cinstr |
| ex_ready | input | 1 | Execute stage takes the offered micro-op |
| uop_valid | output | 1 | A micro-op is offered |
| uop_instr | output | 32 | Expanded 32-bit micro-op |
| seq_start | output | 1 | Stream accepted, first micro-op not yet taken |
| in_seq | output | 1 | A stream is running |
| atomic_tail | output | 1 | Offered micro-op is in the trap-masked tail |
| held_pc | output | PC_W | Address of the originating instruction |
| seq_next_pc | output | PC_W | Sequential address after the originating instruction |
| retire | output | 1 | One-cycle retirement pulse per stream |
| illegal | output | 1 | Offered word is an illegal encoding in the group |

## Verification
The hardest case to reach from the ports is a new word arriving in the middle of a running stream, together with an execute stage that stalls inside the masked tail. The bench starts a long pop-and-return-with-zero and a full thirteen-register push with `ex_ready` following a stall pattern. In the second of these it pulses `cvalid` with another legal word partway through. The scoreboard must then see exactly the first stream, with the tail flag lined up across the stalls, a single retire pulse and no trailing stream.

// File: rtl/zcmp_seq_pkg.sv
package zcmp_seq_pkg;

    localparam int ILEN = 32;
    localparam int IDX_W = 5;

    localparam logic [4:0] R_ZERO = 5'd0;
    localparam logic [4:0] R_RA   = 5'd1;
    localparam logic [4:0] R_SP   = 5'd2;
    localparam logic [4:0] R_A0   = 5'd10;
    localparam logic [4:0] R_A1   = 5'd11;

    localparam logic [6:0] OPC_LOAD  = 7'b0000011;
    localparam logic [6:0] OPC_STORE = 7'b0100011;
    localparam logic [6:0] OPC_IMM   = 7'b0010011;
    localparam logic [6:0] OPC_JALR  = 7'b1100111;

    typedef enum logic [2:0] {
        ZOP_NONE    = 3'd0,
        ZOP_PUSH    = 3'd1,
        ZOP_POP     = 3'd2,
        ZOP_POPRET  = 3'd3,
        ZOP_POPRETZ = 3'd4,
        ZOP_MV_TO_S = 3'd5,
        ZOP_MV_TO_A = 3'd6
    } zop_e;

    typedef struct packed {
        zop_e       op;
        logic [3:0] rlist;
        logic [1:0] spimm;
        logic [2:0] sa;
        logic [2:0] sb;
    } zfields_t;

    function automatic logic [ILEN-1:0] enc_i(input logic [11:0] imm, input logic [4:0] rs1,
                                              input logic [2:0] f3, input logic [4:0] rd,
                                              input logic [6:0] opc);
        return {imm, rs1, f3, rd, opc};
    endfunction

    function automatic logic [ILEN-1:0] enc_s(input logic [11:0] imm, input logic [4:0] rs2,
                                              input logic [4:0] rs1, input logic [2:0] f3,
                                              input logic [6:0] opc);
        return {imm[11:5], rs2, rs1, f3, imm[4:0], opc};
    endfunction

    // k-th register of a saved list: ra, s0, s1, s2..s11
    function automatic logic [4:0] list_reg(input logic [3:0] k);
        logic [4:0] r;
        case (k)
            4'd0:    r = R_RA;
            4'd1:    r = 5'd8;
            4'd2:    r = 5'd9;
            default: r = {1'b0, k} + 5'd15;
        endcase
        return r;
    endfunction

    // 3-bit saved-register selector used by the paired moves
    function automatic logic [4:0] sreg(input logic [2:0] s);
        return (s < 3'd2) ? (5'd8 + {2'b00, s}) : (5'd16 + {2'b00, s});
    endfunction

    function automatic logic [3:0] reg_count(input logic [3:0] rlist);
        return (rlist == 4'd15) ? 4'd13 : (rlist - 4'd3);
    endfunction

    function automatic logic [7:0] stack_adj(input logic [3:0] rlist, input logic [1:0] spimm);
        logic [7:0] base;
        base = {2'b00, reg_count(rlist), 2'b00};
        base = (base + 8'd15) & 8'hF0;
        return base + {2'b00, spimm, 4'b0000};
    endfunction

    function automatic logic [IDX_W-1:0] tail_len(input zop_e op);
        logic [IDX_W-1:0] t;
        case (op)
            ZOP_POPRET:  t = 5'd1;
            ZOP_POPRETZ: t = 5'd2;
            default:     t = 5'd0;
        endcase
        return t;
    endfunction

    function automatic logic [IDX_W-1:0] seq_len(input zfields_t f);
        logic [IDX_W-1:0] n;
        logic [IDX_W-1:0] l;
        n = {1'b0, reg_count(f.rlist)};
        case (f.op)
            ZOP_PUSH, ZOP_POP:         l = n + 5'd1;
            ZOP_POPRET, ZOP_POPRETZ:   l = n + 5'd1 + tail_len(f.op);
            ZOP_MV_TO_S, ZOP_MV_TO_A:  l = 5'd2;
            default:                   l = 5'd1;
        endcase
        return l;
    endfunction

endpackage

// File: rtl/zcmp_decode.sv
module zcmp_decode
    import zcmp_seq_pkg::*;
(
    input  logic [15:0] word,
    output zfields_t    fields,
    output logic        legal,
    output logic        bad
);
    logic in_group;
    logic push_family;

    assign in_group = (word[1:0] == 2'b10) && (word[15:13] == 3'b101);

    always_comb begin
        fields.rlist = word[7:4];
        fields.spimm = word[3:2];
        fields.sa    = word[9:7];
        fields.sb    = word[4:2];
        fields.op    = ZOP_NONE;
        push_family  = 1'b0;
        bad          = 1'b0;
        if (in_group) begin
            if (word[12:10] == 3'b011) begin
                case (word[6:5])
                    2'b01:   fields.op = ZOP_MV_TO_S;
                    2'b11:   fields.op = ZOP_MV_TO_A;
                    default: bad = 1'b1;
                endcase
            end else begin
                push_family = 1'b1;
                case (word[12:8])
                    5'b11000: fields.op = ZOP_PUSH;
                    5'b11010: fields.op = ZOP_POP;
                    5'b11110: fields.op = ZOP_POPRET;
                    5'b11100: fields.op = ZOP_POPRETZ;
                    default: begin
                        bad         = 1'b1;
                        push_family = 1'b0;
                    end
                endcase
            end
            if (push_family && (word[7:4] < 4'd4)) begin
                bad       = 1'b1;
                fields.op = ZOP_NONE;
            end
        end
    end

    assign legal = in_group && !bad && (fields.op != ZOP_NONE);

endmodule

// File: rtl/zcmp_uop_gen.sv
module zcmp_uop_gen
    import zcmp_seq_pkg::*;
(
    input  zfields_t              f,
    input  logic [IDX_W-1:0]      idx,
    output logic [ILEN-1:0]       instr
);
    logic [IDX_W-1:0] n;
    logic [7:0]       adj;
    logic [11:0]      slot_off;
    logic [11:0]      adj12;

    assign n        = {1'b0, reg_count(f.rlist)};
    assign adj      = stack_adj(f.rlist, f.spimm);
    assign adj12    = {4'b0000, adj};
    assign slot_off = {5'b00000, idx, 2'b00} + 12'd4;

    always_comb begin
        instr = enc_i(12'd0, R_ZERO, 3'b000, R_ZERO, OPC_IMM);
        case (f.op)
            ZOP_PUSH: begin
                if (idx < n)
                    instr = enc_s(12'd0 - slot_off, list_reg(idx[3:0]), R_SP, 3'b010, OPC_STORE);
                else
                    instr = enc_i(12'd0 - adj12, R_SP, 3'b000, R_SP, OPC_IMM);
            end
            ZOP_POP, ZOP_POPRET, ZOP_POPRETZ: begin
                if (idx < n)
                    instr = enc_i(adj12 - slot_off, R_SP, 3'b010, list_reg(idx[3:0]), OPC_LOAD);
                else if (idx == n)
                    instr = enc_i(adj12, R_SP, 3'b000, R_SP, OPC_IMM);
                else if ((f.op == ZOP_POPRETZ) && (idx == n + 5'd1))
                    instr = enc_i(12'd0, R_ZERO, 3'b000, R_A0, OPC_IMM);
                else
                    instr = enc_i(12'd0, R_RA, 3'b000, R_ZERO, OPC_JALR);
            end
            ZOP_MV_TO_S: begin
                if (idx == 5'd0)
                    instr = enc_i(12'd0, R_A0, 3'b000, sreg(f.sa), OPC_IMM);
                else
                    instr = enc_i(12'd0, R_A1, 3'b000, sreg(f.sb), OPC_IMM);
            end
            ZOP_MV_TO_A: begin
                if (idx == 5'd0)
                    instr = enc_i(12'd0, sreg(f.sa), 3'b000, R_A0, OPC_IMM);
                else
                    instr = enc_i(12'd0, sreg(f.sb), 3'b000, R_A1, OPC_IMM);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/zcmp_ctx.sv
module zcmp_ctx #(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            accept,
    input  logic [PC_W-1:0] pc_in,
    input  logic            active,
    input  logic            first_fire,
    output logic [PC_W-1:0] held_pc,
    output logic [PC_W-1:0] next_pc,
    output logic            start_evt,
    output logic            retire
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held_pc   <= '0;
            start_evt <= 1'b0;
        end else begin
            if (accept) begin
                held_pc   <= pc_in;
                start_evt <= 1'b1;
            end else if (first_fire) begin
                start_evt <= 1'b0;
            end
        end
    end

    assign next_pc = held_pc + PC_W'(2);
    assign retire  = first_fire;

    // R6: held address frozen for the life of a stream
    a_r6_pc_frozen: assert property (@(posedge clk) disable iff (rst)
        (active && $past(active)) |-> $stable(held_pc));

    // R8: retirement only on the first micro-op, while the start event is pending
    a_r8_retire_first: assert property (@(posedge clk) disable iff (rst)
        retire |-> start_evt);

    // R8: start event never outlives its stream
    a_r8_start_in_seq: assert property (@(posedge clk) disable iff (rst)
        start_evt |-> active);

endmodule

// File: rtl/zcmp_seq.sv
module zcmp_seq
    import zcmp_seq_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [15:0]     cinstr,
    input  logic            cvalid,
    input  logic [PC_W-1:0] pc_in,
    input  logic            ex_ready,
    output logic            uop_valid,
    output logic [ILEN-1:0] uop_instr,
    output logic            seq_start,
    output logic            in_seq,
    output logic            atomic_tail,
    output logic [PC_W-1:0] held_pc,
    output logic [PC_W-1:0] seq_next_pc,
    output logic            retire,
    output logic            illegal
);
    zfields_t         dec_f;
    logic             dec_legal;
    logic             dec_bad;
    zfields_t         cur_f;
    logic [IDX_W-1:0] idx_q;
    logic             active_q;
    logic             accept;
    logic             fire;
    logic [IDX_W-1:0] len;
    logic [IDX_W-1:0] tlen;
    logic             last;

    zcmp_decode u_dec (
        .word   (cinstr),
        .fields (dec_f),
        .legal  (dec_legal),
        .bad    (dec_bad)
    );

    assign accept  = cvalid && !active_q && dec_legal;
    assign illegal = cvalid && !active_q && dec_bad;
    assign fire    = active_q && ex_ready;
    assign len     = seq_len(cur_f);
    assign tlen    = tail_len(cur_f.op);
    assign last    = (idx_q == len - 5'd1);

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            idx_q    <= '0;
            cur_f    <= '{op: ZOP_NONE, rlist: 4'd0, spimm: 2'd0, sa: 3'd0, sb: 3'd0};
        end else if (accept) begin
            active_q <= 1'b1;
            idx_q    <= '0;
            cur_f    <= dec_f;
        end else if (fire) begin
            if (last) begin
                active_q <= 1'b0;
                idx_q    <= '0;
            end else begin
                idx_q <= idx_q + 5'd1;
            end
        end
    end

    zcmp_uop_gen u_gen (
        .f     (cur_f),
        .idx   (idx_q),
        .instr (uop_instr)
    );

    zcmp_ctx #(.PC_W(PC_W)) u_ctx (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .pc_in      (pc_in),
        .active     (active_q),
        .first_fire (fire && (idx_q == '0)),
        .held_pc    (held_pc),
        .next_pc    (seq_next_pc),
        .start_evt  (seq_start),
        .retire     (retire)
    );

    assign uop_valid   = active_q;
    assign in_seq      = active_q;
    assign atomic_tail = active_q && (tlen != '0) && (idx_q >= len - tlen);

    // R7: an offered micro-op is held until taken
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (uop_valid && !ex_ready) |=> (uop_valid && $stable(uop_instr)));

    // R9: the masked tail only ends together with the stream
    a_r9_tail_to_end: assert property (@(posedge clk) disable iff (rst)
        $fell(atomic_tail) |-> !in_seq);

    // R3: an illegal word never starts a stream
    a_r3_no_start: assert property (@(posedge clk) disable iff (rst)
        illegal |=> !in_seq);

    // R10: no new start while a stream is running
    a_r10_busy_ignore: assert property (@(posedge clk) disable iff (rst)
        (in_seq && !(fire && last)) |=> (in_seq && !seq_start || $stable(held_pc)));

endmodule

// File: tb/zcmp_seq_bench.sv
module zcmp_seq_bench;
    localparam int PC_W = 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [15:0]     cinstr = 16'h0;
    logic            cvalid = 1'b0;
    logic [PC_W-1:0] pc_in = '0;
    logic            ex_ready = 1'b1;
    logic            uop_valid;
    logic [31:0]     uop_instr;
    logic            seq_start, in_seq, atomic_tail, retire, illegal;
    logic [PC_W-1:0] held_pc, seq_next_pc;

    zcmp_seq #(.PC_W(PC_W)) u_zcmp_seq (
        .clk(clk), .rst(rst), .cinstr(cinstr), .cvalid(cvalid), .pc_in(pc_in),
        .ex_ready(ex_ready), .uop_valid(uop_valid), .uop_instr(uop_instr),
        .seq_start(seq_start), .in_seq(in_seq), .atomic_tail(atomic_tail),
        .held_pc(held_pc), .seq_next_pc(seq_next_pc), .retire(retire), .illegal(illegal)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int fails = 0;
    int retires = 0;
    int rcnt = 0;
    bit stall = 1'b0;
    bit done = 1'b0;
    logic [32:0] exp_q[$];
    logic [PC_W-1:0] exp_pc = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // ---------- independent reference expansion ----------
    function automatic logic [31:0] ri(int imm, int rs1, int f3, int rd, logic [6:0] opc);
        logic [11:0] i12 = 12'(imm);
        return {i12, 5'(rs1), 3'(f3), 5'(rd), opc};
    endfunction
    function automatic logic [31:0] rs(int imm, int rs2, int rs1);
        logic [11:0] i12 = 12'(imm);
        return {i12[11:5], 5'(rs2), 5'(rs1), 3'd2, i12[4:0], 7'b0100011};
    endfunction
    function automatic int lreg(int k);
        if (k == 0) return 1;
        if (k == 1) return 8;
        if (k == 2) return 9;
        return 15 + k;
    endfunction
    function automatic int sr(int s);
        return (s < 2) ? 8 + s : 16 + s;
    endfunction

    // kind: 0 push, 1 pop, 2 popret, 3 popretz
    function automatic logic [15:0] stk_word(int kind, int rlist, int spimm);
        logic [4:0] sel;
        case (kind)
            0: sel = 5'b11000;
            1: sel = 5'b11010;
            2: sel = 5'b11110;
            default: sel = 5'b11100;
        endcase
        return {3'b101, sel, 4'(rlist), 2'(spimm), 2'b10};
    endfunction
    function automatic logic [15:0] mv_word(bit to_a, int sa, int sb);
        return {3'b101, 3'b011, 3'(sa), to_a ? 2'b11 : 2'b01, 3'(sb), 2'b10};
    endfunction

    task automatic exp_stack(int kind, int rlist, int spimm);
        int n = (rlist == 15) ? 13 : rlist - 3;
        int adj = ((4 * n + 15) / 16) * 16 + 16 * spimm;
        for (int k = 0; k < n; k++) begin
            if (kind == 0) exp_q.push_back({1'b0, rs(-4 * (k + 1), lreg(k), 2)});
            else           exp_q.push_back({1'b0, ri(adj - 4 * (k + 1), 2, 2, lreg(k), 7'b0000011)});
        end
        exp_q.push_back({1'b0, ri((kind == 0) ? -adj : adj, 2, 0, 2, 7'b0010011)});
        if (kind == 3) exp_q.push_back({1'b1, ri(0, 0, 0, 10, 7'b0010011)});
        if (kind >= 2) exp_q.push_back({1'b1, ri(0, 1, 0, 0, 7'b1100111)});
    endtask

    task automatic exp_mv(bit to_a, int sa, int sb);
        if (!to_a) begin
            exp_q.push_back({1'b0, ri(0, 10, 0, sr(sa), 7'b0010011)});
            exp_q.push_back({1'b0, ri(0, 11, 0, sr(sb), 7'b0010011)});
        end else begin
            exp_q.push_back({1'b0, ri(0, sr(sa), 0, 10, 7'b0010011)});
            exp_q.push_back({1'b0, ri(0, sr(sb), 0, 11, 7'b0010011)});
        end
    endtask

    // ---------- execute-side ready pattern ----------
    always @(posedge clk) begin
        #1;
        rcnt++;
        ex_ready = stall ? ((rcnt % 3) != 0) : 1'b1;
    end

    // ---------- monitor / scoreboard ----------
    always @(negedge clk) begin
        if (!rst) begin
            if (retire) retires++;
            if (uop_valid && ex_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R10", "unexpected micro-op", uop_instr, 32'h0);
                end else begin
                    logic [32:0] e;
                    e = exp_q.pop_front();
                    chk(uop_instr == e[31:0], "R4/R5/R2", "micro-op", uop_instr, e[31:0]);
                    chk(atomic_tail == e[32], "R9", "atomic_tail", 32'(atomic_tail), 32'(e[32]));
                    chk(held_pc == exp_pc, "R6", "held_pc", held_pc, exp_pc);
                    chk(seq_next_pc == exp_pc + 2, "R6", "seq_next_pc", seq_next_pc, exp_pc + 2);
                end
            end
        end
    end

    task automatic run_seq(input logic [15:0] w, input logic [PC_W-1:0] pc, input bit inject);
        int r0 = retires;
        exp_pc = pc;
        @(posedge clk); #2;
        cinstr = w; pc_in = pc; cvalid = 1'b1;
        @(posedge clk); #2;
        cvalid = 1'b0; pc_in = 32'hDEAD_0000;
        @(negedge clk);
        chk(in_seq == 1'b1, "R1", "in_seq after accept", 32'(in_seq), 32'd1);
        chk(seq_start == 1'b1, "R8", "seq_start after accept", 32'(seq_start), 32'd1);
        if (inject) begin
            @(posedge clk); #2;
            cinstr = stk_word(0, 4, 0); pc_in = 32'h0000_0F00; cvalid = 1'b1;
            @(posedge clk); #2;
            cvalid = 1'b0;
        end
        while (in_seq) @(negedge clk);
        chk(exp_q.size() == 0, "R7", "stream fully delivered", 32'(exp_q.size()), 32'd0);
        chk(retires == r0 + 1, "R8", "retire count", 32'(retires - r0), 32'd1);
        repeat (2) @(negedge clk);
        chk(in_seq == 1'b0, "R10", "no stream after end", 32'(in_seq), 32'd0);
        chk(seq_start == 1'b0, "R8", "seq_start cleared", 32'(seq_start), 32'd0);
    endtask

    task automatic try_bad(input logic [15:0] w, input bit exp_ill, input string req);
        @(posedge clk); #2;
        cinstr = w; cvalid = 1'b1;
        @(negedge clk);
        chk(illegal == exp_ill, req, "illegal flag", 32'(illegal), 32'(exp_ill));
        @(posedge clk); #2;
        cvalid = 1'b0;
        @(negedge clk);
        chk(in_seq == 1'b0, req, "no stream started", 32'(in_seq), 32'd0);
        chk(uop_valid == 1'b0, req, "no micro-op", 32'(uop_valid), 32'd0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk({in_seq, uop_valid, seq_start, atomic_tail, retire} == 5'b0, "R11", "reset outputs",
            32'({in_seq, uop_valid, seq_start, atomic_tail, retire}), 32'd0);

        // R1/R4 push variants
        exp_stack(0, 4, 0);  run_seq(stk_word(0, 4, 0), 32'h0000_1000, 1'b0);
        exp_stack(0, 7, 2);  run_seq(stk_word(0, 7, 2), 32'h0000_1010, 1'b0);
        exp_stack(0, 12, 1); run_seq(stk_word(0, 12, 1), 32'h0000_1020, 1'b0);
        // R5 pop variants
        exp_stack(1, 5, 1);  run_seq(stk_word(1, 5, 1), 32'h0000_2000, 1'b0);
        exp_stack(2, 6, 0);  run_seq(stk_word(2, 6, 0), 32'h0000_2002, 1'b0);
        exp_stack(3, 4, 3);  run_seq(stk_word(3, 4, 3), 32'h0000_2004, 1'b0);
        // R2 paired moves
        exp_mv(1'b0, 1, 5);  run_seq(mv_word(1'b0, 1, 5), 32'h0000_3000, 1'b0);
        exp_mv(1'b1, 0, 7);  run_seq(mv_word(1'b1, 0, 7), 32'h0000_3002, 1'b0);

        // R7/R9 under stalls, including the masked tail
        stall = 1'b1;
        exp_stack(3, 15, 2); run_seq(stk_word(3, 15, 2), 32'h0000_4000, 1'b0);
        exp_stack(2, 9, 1);  run_seq(stk_word(2, 9, 1), 32'h0000_4010, 1'b0);
        exp_mv(1'b0, 3, 2);  run_seq(mv_word(1'b0, 3, 2), 32'h0000_4020, 1'b0);
        // R10 word offered mid-stream is ignored
        exp_stack(0, 15, 3); run_seq(stk_word(0, 15, 3), 32'h0000_5000, 1'b1);
        stall = 1'b0;

        // R3 illegal encodings
        try_bad({3'b101, 5'b11001, 4'd5, 2'd0, 2'b10}, 1'b1, "R3");
        try_bad(stk_word(0, 3, 0), 1'b1, "R3");
        try_bad(stk_word(1, 0, 1), 1'b1, "R3");
        try_bad({3'b101, 3'b011, 3'd1, 2'b00, 3'd2, 2'b10}, 1'b1, "R3");
        // R10 words outside the group
        try_bad(16'h4501, 1'b0, "R10");
        try_bad({3'b100, 5'b11000, 4'd5, 2'd0, 2'b10}, 1'b0, "R10");

        // still works afterwards
        exp_stack(3, 8, 0);  run_seq(stk_word(3, 8, 0), 32'h0000_6000, 1'b0);

        finish_run();
    end

endmodule